// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Register Bank

This block is a compact 32-bit memory-mapped register bank. Each register can be reached at four consecutive word addresses. The first address is a plain read/write alias. The other three apply an atomic bitwise operation to the stored value, so software can change a few bits in one bus write without a read-modify-write sequence. The bank holds two configuration words, one sticky status word whose flags are raised by hardware pulses, and one read-only word that captures a signed measurement sample each time the producer strobes it.

The bank has no software reset. Every configuration bit can therefore be forced to a known value with a plain write. The only way to drop a status flag is a write to that register's clear alias. Software can read the status word and write the same value back to the clear alias, which removes exactly the flags it observed. A flag that hardware raises in the same cycle as that clear survives it. The bus is a single-cycle valid/write/address/data request. Read data comes back registered on the following cycle.

Top module: `regbank_alias`

## Requirements
- R1: After reset, ctrl0 reads as the CTRL0_RST parameter, ctrl1 reads as CTRL1_RST, and both the status flags and the sample word read as zero. The `ctrl0_o`, `ctrl1_o` and `flags_o` ports show the same values.
- R2: The register bases are ctrl0 at 0x000, status at 0x010, sample at 0x020 and ctrl1 at 0x200. Address bits [3:2] select the alias: 0 is plain, 1 is set, 2 is clear and 3 is toggle. A plain-alias write replaces the whole control register. A control register with no write addressed to it keeps its value.
- R3: A write to a control register's set alias (bits [3:2] = 1) ORs the write data into it.
- R4: A write to a control register's clear alias (bits [3:2] = 2) ANDs it with the inverted write data.
- R5: A write to a control register's toggle alias (bits [3:2] = 3) XORs the write data into it.
- R6: A one on bit i of `hw_flag_set` at a clock edge sets status flag i. The flag then stays set until it is cleared through the clear alias.
- R7: A write of mask M to the status clear alias (0x018) clears exactly the flags where M has a one. Writing back a value just read therefore clears only the flags seen in that read.
- R8: Writes to the status word's plain, set and toggle aliases (0x010, 0x014, 0x01C) leave every flag unchanged.
- R9: When `hw_flag_set` bit i and a clear-alias write with a one on bit i occur in the same cycle, flag i is set afterwards.
- R10: A clock edge with `sample_valid` high loads `sample_data` into the sample word. The sample word reads back sign-extended to 32 bits. Writes to any of its aliases (0x020 to 0x02C) leave it unchanged.
- R11: A read at any alias of a register returns that register's current value on `bus_rdata` in the cycle after the request. A read of an unmapped address returns zero, and a write to an unmapped address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request strobe, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address; bits [3:2] select the alias |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| hw_flag_set | input | STAT_W | Per-flag hardware set pulses |
| sample_valid | input | 1 | Load strobe for the sample word |
| sample_data | input | DATA_W | Signed sample value |
| ctrl0_o | output | CTRL_W | Current ctrl0 contents |
| ctrl1_o | output | CTRL_W | Current ctrl1 contents |
| flags_o | output | STAT_W | Current status flags |

## Verification
A wrong alias decode or a bad operator would leave a control word off by a bit pattern. That error is visible on `ctrl0_o` or `ctrl1_o` on the cycle after the write, and on `bus_rdata` one cycle after the next read. A status flag that is lost, or set when it should not be, stays wrong until the next clear. Each status step is therefore read back straight away, including the cycle where a hardware pulse collides with a clear. A sample word that takes a bus write keeps the corrupt value until the next strobe, so it is read back after writes to every one of its aliases.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

   localparam int unsigned BUS_W = 32;

   // alias selected by address bits [3:2]
   typedef enum logic [1:0] {
      OP_WRITE  = 2'd0,
      OP_SET    = 2'd1,
      OP_CLEAR  = 2'd2,
      OP_TOGGLE = 2'd3
   } alias_op_e;

   function automatic logic [BUS_W-1:0] apply_op(alias_op_e op,
                                                  logic [BUS_W-1:0] cur,
                                                  logic [BUS_W-1:0] d);
      logic [BUS_W-1:0] r;
      case (op)
         OP_WRITE:  r = d;
         OP_SET:    r = cur | d;
         OP_CLEAR:  r = cur & ~d;
         default:   r = cur ^ d;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/regbank_decode.sv
module regbank_decode
   import regbank_pkg::*;
#(
   parameter int unsigned AW        = 12,
   parameter int unsigned CTRL0_BASE = 'h000,
   parameter int unsigned CTRL1_BASE = 'h200,
   parameter int unsigned STAT_BASE  = 'h010,
   parameter int unsigned DATA_BASE  = 'h020
)(
   input  logic [AW-1:2] addr_w,
   output alias_op_e     op,
   output logic [1:0]    hit_ctrl,
   output logic          hit_stat,
   output logic          hit_data
);
   localparam logic [AW-1:0] C0_A = AW'(CTRL0_BASE);
   localparam logic [AW-1:0] C1_A = AW'(CTRL1_BASE);
   localparam logic [AW-1:0] ST_A = AW'(STAT_BASE);
   localparam logic [AW-1:0] DT_A = AW'(DATA_BASE);

   assign op          = alias_op_e'(addr_w[3:2]);
   assign hit_ctrl[0] = (addr_w[AW-1:4] == C0_A[AW-1:4]);
   assign hit_ctrl[1] = (addr_w[AW-1:4] == C1_A[AW-1:4]);
   assign hit_stat    = (addr_w[AW-1:4] == ST_A[AW-1:4]);
   assign hit_data    = (addr_w[AW-1:4] == DT_A[AW-1:4]);
endmodule

// File: rtl/regbank_ctrl_reg.sv
module regbank_ctrl_reg
   import regbank_pkg::*;
#(
   parameter int unsigned W   = 32,
   parameter logic [W-1:0] RST = '0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  alias_op_e    op,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   assign nxt = W'(apply_op(op, BUS_W'(q), BUS_W'(wdata)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST;
      else if (wr_en) q <= nxt;
   end

   AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(q)); // R2
   AST_CTRL_SET:  assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata))); // R3
   AST_CTRL_CLR:  assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op == OP_CLEAR) |=> ((q & $past(wdata)) == '0)); // R4
   AST_CTRL_TOG:  assert property (@(posedge clk) disable iff (!rst_n) (wr_en && op == OP_TOGGLE) |=> ((q ^ $past(q)) == $past(wdata))); // R5
endmodule

// File: rtl/regbank_w1c.sv
module regbank_w1c #(
   parameter int unsigned W = 8
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] hw_set,
   input  logic         clr_en,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] flags
);
   logic [W-1:0] drop;

   assign drop = clr_en ? clr_mask : '0;

   // hardware set is applied after the clear, so it wins a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~drop) | hw_set;
   end

   AST_HW_WINS:  assert property (@(posedge clk) disable iff (!rst_n) (hw_set != '0) |=> ((flags & $past(hw_set)) == $past(hw_set))); // R9
   AST_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) !clr_en |=> ((flags & $past(flags)) == $past(flags))); // R6
   AST_ONLY_HW:  assert property (@(posedge clk) disable iff (!rst_n) (flags & ~$past(flags) & ~$past(hw_set)) == '0); // R8
endmodule

// File: rtl/regbank_sample.sv
module regbank_sample #(
   parameter int unsigned W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !load |=> $stable(q)); // R10
endmodule

// File: rtl/regbank_alias.sv
module regbank_alias
   import regbank_pkg::*;
#(
   parameter int unsigned AW          = 12,
   parameter int unsigned CTRL_W      = 32,
   parameter int unsigned STAT_W      = 8,
   parameter int unsigned DATA_W      = 16,
   parameter bit          DATA_SIGNED = 1'b1,
   parameter bit          RDATA_REG   = 1'b1,
   parameter int unsigned CTRL0_BASE  = 'h000,
   parameter int unsigned CTRL1_BASE  = 'h200,
   parameter int unsigned STAT_BASE   = 'h010,
   parameter int unsigned DATA_BASE   = 'h020,
   parameter logic [31:0] CTRL0_RST   = 32'h0000_0C0F,
   parameter logic [31:0] CTRL1_RST   = 32'h8000_0004
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [AW-1:0]     bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [STAT_W-1:0] hw_flag_set,
   input  logic              sample_valid,
   input  logic [DATA_W-1:0] sample_data,
   output logic [CTRL_W-1:0] ctrl0_o,
   output logic [CTRL_W-1:0] ctrl1_o,
   output logic [STAT_W-1:0] flags_o
);
   localparam int unsigned NUM_CTRL = 2;

   // elaboration-time parameter checks
   if (CTRL_W < 1 || CTRL_W > BUS_W) begin : g_bad_ctrl_w
      $error("CTRL_W must lie in 1..32");
   end
   if (STAT_W < 1 || STAT_W > BUS_W) begin : g_bad_stat_w
      $error("STAT_W must lie in 1..32");
   end
   if (DATA_W < 1 || DATA_W >= BUS_W) begin : g_bad_data_w
      $error("DATA_W must lie in 1..31");
   end
   if (AW < 5 || AW > 32) begin : g_bad_aw
      $error("AW must lie in 5..32");
   end
   if (((CTRL0_BASE | CTRL1_BASE | STAT_BASE | DATA_BASE) & 'hF) != 0) begin : g_bad_align
      $error("register bases must be 16-byte aligned");
   end
   if ((CTRL0_BASE >> AW) != 0 || (CTRL1_BASE >> AW) != 0 ||
       (STAT_BASE >> AW) != 0 || (DATA_BASE >> AW) != 0) begin : g_bad_range
      $error("a register base does not fit in AW bits");
   end

   alias_op_e               op;
   logic [NUM_CTRL-1:0]     hit_ctrl;
   logic                    hit_stat;
   logic                    hit_data;
   logic                    bus_wr;
   logic                    bus_rd;
   logic [NUM_CTRL-1:0][CTRL_W-1:0] ctrl_q;
   logic [STAT_W-1:0]       flags_q;
   logic [DATA_W-1:0]       data_q;
   logic [BUS_W-1:0]        data_ext;
   logic [BUS_W-1:0]        rd_val;
   logic                    unused_addr_lsb;

   assign unused_addr_lsb = ^bus_addr[1:0];
   assign bus_wr = bus_valid & bus_write;
   assign bus_rd = bus_valid & ~bus_write;

   regbank_decode #(
      .AW(AW), .CTRL0_BASE(CTRL0_BASE), .CTRL1_BASE(CTRL1_BASE),
      .STAT_BASE(STAT_BASE), .DATA_BASE(DATA_BASE)
   ) i_decode (
      .addr_w   (bus_addr[AW-1:2]),
      .op       (op),
      .hit_ctrl (hit_ctrl),
      .hit_stat (hit_stat),
      .hit_data (hit_data)
   );

   for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
      localparam logic [CTRL_W-1:0] RST_V = (gi == 0) ? CTRL_W'(CTRL0_RST) : CTRL_W'(CTRL1_RST);
      regbank_ctrl_reg #(.W(CTRL_W), .RST(RST_V)) i_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .wr_en (bus_wr & hit_ctrl[gi]),
         .op    (op),
         .wdata (bus_wdata[CTRL_W-1:0]),
         .q     (ctrl_q[gi])
      );
   end

   regbank_w1c #(.W(STAT_W)) i_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (hw_flag_set),
      .clr_en   (bus_wr & hit_stat & (op == OP_CLEAR)),
      .clr_mask (bus_wdata[STAT_W-1:0]),
      .flags    (flags_q)
   );

   regbank_sample #(.W(DATA_W)) i_sample (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (sample_valid),
      .din   (sample_data),
      .q     (data_q)
   );

   if (DATA_SIGNED) begin : g_sext
      assign data_ext = {{(BUS_W-DATA_W){data_q[DATA_W-1]}}, data_q};
   end else begin : g_zext
      assign data_ext = {{(BUS_W-DATA_W){1'b0}}, data_q};
   end

   always_comb begin
      rd_val = '0;
      if (hit_ctrl[0])      rd_val[CTRL_W-1:0] = ctrl_q[0];
      else if (hit_ctrl[1]) rd_val[CTRL_W-1:0] = ctrl_q[1];
      else if (hit_stat)    rd_val[STAT_W-1:0] = flags_q;
      else if (hit_data)    rd_val             = data_ext;
   end

   if (RDATA_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      bus_rdata <= '0;
         else if (bus_rd) bus_rdata <= rd_val;
      end

      AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_rd && hit_ctrl == '0 && !hit_stat && !hit_data) |=> (bus_rdata == '0)); // R11
      AST_RDATA_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !bus_rd |=> $stable(bus_rdata)); // R11
   end else begin : g_rd_comb
      assign bus_rdata = bus_rd ? rd_val : '0;
   end

   assign ctrl0_o = ctrl_q[0];
   assign ctrl1_o = ctrl_q[1];
   assign flags_o = flags_q;

   AST_DATA_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (bus_wr && hit_data && !sample_valid) |=> $stable(data_q)); // R10
endmodule

// File: tb/test_regbank_alias.sv
`timescale 1ns/1ps
module test_regbank_alias;
   localparam int unsigned AW = 12;
   localparam logic [31:0] C0_RST = 32'h0000_0C0F;
   localparam logic [31:0] C1_RST = 32'h8000_0004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [7:0]  hw_flag_set = '0;
   logic        sample_valid = 1'b0;
   logic [15:0] sample_data = '0;
   logic [31:0] ctrl0_o, ctrl1_o;
   logic [7:0]  flags_o;

   always #2 clk = ~clk;

   regbank_alias #(
      .AW(AW), .CTRL_W(32), .STAT_W(8), .DATA_W(16), .DATA_SIGNED(1'b1), .RDATA_REG(1'b1),
      .CTRL0_BASE('h000), .CTRL1_BASE('h200), .STAT_BASE('h010), .DATA_BASE('h020),
      .CTRL0_RST(C0_RST), .CTRL1_RST(C1_RST)
   ) i_regbank_alias (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .hw_flag_set(hw_flag_set), .sample_valid(sample_valid), .sample_data(sample_data),
      .ctrl0_o(ctrl0_o), .ctrl1_o(ctrl1_o), .flags_o(flags_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // reference model, built from the requirements
   logic [31:0] m_ctrl0 = C0_RST;
   logic [31:0] m_ctrl1 = C1_RST;
   logic [7:0]  m_stat = '0;
   logic [31:0] m_data = '0;

   string       tag_q[$];
   logic [31:0] exp_q[$];

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] op_apply(logic [1:0] al, logic [31:0] cur, logic [31:0] d);
      case (al)
         2'd0: return d;
         2'd1: return cur | d;
         2'd2: return cur & ~d;
         default: return cur ^ d;
      endcase
   endfunction

   function automatic logic [31:0] model_read(logic [AW-1:0] a);
      case ({a[AW-1:4], 4'h0})
         12'h000: return m_ctrl0;
         12'h200: return m_ctrl1;
         12'h010: return {24'h0, m_stat};
         12'h020: return m_data;
         default: return 32'h0;
      endcase
   endfunction

   // monitor: compares each returned read word with the queued expectation
   logic rd_pend = 1'b0;
   always @(posedge clk) rd_pend <= bus_valid && !bus_write;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (tag_q.size() == 0) chk("R11 unexpected read return", bus_rdata, 32'h0);
         else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
   end

   task automatic bus_wr(logic [AW-1:0] a, logic [31:0] d, logic [7:0] hw = 8'h0);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; hw_flag_set = hw;
      case ({a[AW-1:4], 4'h0})
         12'h000: m_ctrl0 = op_apply(a[3:2], m_ctrl0, d);
         12'h200: m_ctrl1 = op_apply(a[3:2], m_ctrl1, d);
         12'h010: if (a[3:2] == 2'd2) m_stat = m_stat & ~d[7:0];
         default: ;
      endcase
      m_stat = m_stat | hw;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; hw_flag_set = '0;
   endtask

   task automatic bus_rd(logic [AW-1:0] a, string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      tag_q.push_back(tag);
      exp_q.push_back(model_read(a));
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic hw_pulse(logic [7:0] m);
      @(negedge clk);
      hw_flag_set = m; m_stat = m_stat | m;
      @(negedge clk);
      hw_flag_set = '0;
   endtask

   task automatic sample(logic [15:0] v);
      @(negedge clk);
      sample_valid = 1'b1; sample_data = v;
      m_data = {{16{v[15]}}, v};
      @(negedge clk);
      sample_valid = 1'b0;
   endtask

   task automatic ports(string tag);
      @(negedge clk);
      chk({tag, " ctrl0_o"}, ctrl0_o, m_ctrl0);
      chk({tag, " ctrl1_o"}, ctrl1_o, m_ctrl1);
      chk({tag, " flags_o"}, {24'h0, flags_o}, {24'h0, m_stat});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      ports("R1 reset");
      bus_rd(12'h000, "R1 ctrl0 reset");
      bus_rd(12'h200, "R1 ctrl1 reset");
      bus_rd(12'h010, "R1 status reset");
      bus_rd(12'h020, "R1 sample reset");
      // R2 plain writes
      bus_wr(12'h000, 32'hA5A5_1234);
      bus_rd(12'h000, "R2 ctrl0 plain write");
      bus_wr(12'h200, 32'h0000_00F0);
      ports("R2 after plain writes");
      // R3 set alias, read back through other aliases (R11)
      bus_wr(12'h204, 32'h0F00_000F);
      bus_rd(12'h208, "R3 ctrl1 set, read via clear alias R11");
      bus_wr(12'h004, 32'h0000_0003);
      bus_rd(12'h00C, "R3 ctrl0 set, read via toggle alias R11");
      // R4 clear alias
      bus_wr(12'h208, 32'h0F00_0030);
      bus_rd(12'h204, "R4 ctrl1 clear");
      bus_wr(12'h008, 32'hFFFF_0000);
      ports("R4 after clear");
      // R5 toggle alias
      bus_wr(12'h20C, 32'hFFFF_0001);
      bus_rd(12'h200, "R5 ctrl1 toggle");
      bus_wr(12'h00C, 32'h8000_8000);
      bus_wr(12'h00C, 32'h0000_8000);
      bus_rd(12'h000, "R5 ctrl0 double toggle");
      // R6 sticky flags
      hw_pulse(8'h05);
      repeat (4) @(negedge clk);
      bus_rd(12'h010, "R6 status sticky");
      // R8 plain / set / toggle writes to status ignored
      bus_wr(12'h010, 32'h0000_0000);
      bus_rd(12'h010, "R8 status plain write ignored");
      bus_wr(12'h014, 32'h0000_00F0);
      bus_wr(12'h01C, 32'h0000_00FF);
      ports("R8 status after set/toggle writes");
      // R7 write back the value seen earlier clears only those flags
      hw_pulse(8'h40);
      bus_wr(12'h018, 32'h0000_0005);
      bus_rd(12'h01C, "R7 status write-back clear");
      // R9 hw set wins over clear in the same cycle
      bus_wr(12'h018, 32'h0000_00C2, 8'h02);
      bus_rd(12'h010, "R9 hw set beats clear");
      ports("R9 flags port");
      // R10 sample capture and read-only behaviour
      sample(16'hFF80);
      bus_rd(12'h020, "R10 negative sample sign-extended");
      bus_wr(12'h020, 32'h1234_5678);
      bus_wr(12'h024, 32'hFFFF_FFFF);
      bus_wr(12'h028, 32'hFFFF_FFFF);
      bus_wr(12'h02C, 32'h0F0F_0F0F);
      bus_rd(12'h02C, "R10 sample writes ignored");
      sample(16'h1A40);
      bus_rd(12'h024, "R10 positive sample");
      // R11 unmapped accesses
      bus_wr(12'h100, 32'hFFFF_FFFF);
      bus_wr(12'h104, 32'hFFFF_FFFF);
      bus_rd(12'h100, "R11 unmapped read zero");
      ports("R11 unmapped write no effect");
      // R2 idle hold
      repeat (5) @(negedge clk);
      ports("R2 idle hold");
      repeat (3) @(negedge clk);
      chk("R11 all reads returned", tag_q.size(), 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule